// File: doc/BRIEF.md
# Masked Time/Date Alarm Comparator

This block watches the calendar registers of a real-time clock and raises two alarms. On every once-per-second update, signalled by a one-cycle `tick` pulse, it compares the current seconds, minutes, hours and day/date values against two sets of alarm registers. The first alarm covers seconds, minutes, hours and day/date. The second alarm covers minutes, hours and day/date, and it can only fire when the current second is 00.

Bit 7 of every alarm register is a mask bit. A masked field drops out of the comparison, so the mask pattern sets how often the alarm repeats. The possible rates run from every second (or every minute for the second alarm) up to a full day-or-date match. Bit 6 of each day/date alarm register chooses whether the low six bits are compared with the day of the week or with the date of the month.

A match sets a sticky flag for that alarm. The flag stays set until software writes 0 to it. The active-low interrupt output is asserted when a flagged alarm is also enabled and the global interrupt-control input is high.

Top module: `alarm_match`

## Requirements
- R1: After reset both alarm flags read 0 and `irq_n` reads 1.
- R2: When `tick` is high, alarm 1 matches if every unmasked field agrees. A field is masked when bit 7 of its alarm register is 1. Seconds and minutes compare bits 6:0. Hours compare bits 6:0 as raw bits, so a difference in the 12/24 bit (bit 6) or the AM/PM bit (bit 5) is a mismatch.
- R3: With all four alarm 1 mask bits set, alarm 1 matches on every `tick`, whatever the time values are.
- R4: Bit 6 of a day/date alarm register selects the compare target. 0 compares bits 5:0 with `cur_mday[5:0]`, and 1 compares them with `cur_wday[5:0]`.
- R5: Alarm 2 matches on a `tick` only when `cur_sec[6:0]` is 0 and its unmasked fields (minutes, hours, day/date, with the same rules as alarm 1) agree. With all three alarm 2 masks set, it matches once per minute at second 00.
- R6: No match is taken, and no flag is set, in a cycle where `tick` is low.
- R7: Flags are sticky. A cycle with `flag_wr` high clears `a1_flag` if `flag_wdata[0]` is 0 and clears `a2_flag` if `flag_wdata[1]` is 0. A written 1 leaves its flag unchanged.
- R8: If a match and a clearing write to the same flag fall in the same cycle, the flag ends up set.
- R9: A match on the clock edge where `tick` is sampled high makes the flag read 1 right after that edge.
- R10: `irq_n` is 0 exactly when `intcn` is 1 and either (`a1_flag` and `a1_ie`) or (`a2_flag` and `a2_ie`) holds. It follows the enable inputs without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse marking the once-per-second update |
| cur_sec | input | 8 | Current seconds register (BCD) |
| cur_min | input | 8 | Current minutes register (BCD) |
| cur_hour | input | 8 | Current hours register, raw encoding |
| cur_wday | input | 8 | Current day-of-week register |
| cur_mday | input | 8 | Current date-of-month register |
| a1_sec | input | 8 | Alarm 1 seconds: bit 7 mask, bits 6:0 value |
| a1_min | input | 8 | Alarm 1 minutes: bit 7 mask, bits 6:0 value |
| a1_hour | input | 8 | Alarm 1 hours: bit 7 mask, bits 6:0 raw value |
| a1_dd | input | 8 | Alarm 1 day/date: bit 7 mask, bit 6 day select, bits 5:0 value |
| a2_min | input | 8 | Alarm 2 minutes: bit 7 mask, bits 6:0 value |
| a2_hour | input | 8 | Alarm 2 hours: bit 7 mask, bits 6:0 raw value |
| a2_dd | input | 8 | Alarm 2 day/date: bit 7 mask, bit 6 day select, bits 5:0 value |
| a1_ie | input | 1 | Alarm 1 interrupt enable |
| a2_ie | input | 1 | Alarm 2 interrupt enable |
| intcn | input | 1 | Global interrupt-control bit |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 2 | Flag write data: bit 0 for alarm 1, bit 1 for alarm 2 |
| a1_flag | output | 1 | Sticky alarm 1 flag |
| a2_flag | output | 1 | Sticky alarm 2 flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest situation to create is a full unmasked match. It needs every compared field to agree on a `tick` cycle, and for alarm 2 the seconds must also be 00. Uniform random values almost never do this. The stimulus therefore draws time values from a small pool and copies the current field into an alarm field about half the time, which makes full and partial matches common. Directed cases cover three further situations: a match and a clearing write in the same cycle, a hour mismatch only in the AM/PM or 12/24 bit, and a day/date select that points at the field that does not agree.

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-1:0] cur_sec,
  input  logic [DW-1:0] cur_min,
  input  logic [DW-1:0] cur_hour,
  input  logic [DW-1:0] cur_wday,
  input  logic [DW-1:0] cur_mday,
  input  logic [DW-1:0] a1_sec,
  input  logic [DW-1:0] a1_min,
  input  logic [DW-1:0] a1_hour,
  input  logic [DW-1:0] a1_dd,
  input  logic [DW-1:0] a2_min,
  input  logic [DW-1:0] a2_hour,
  input  logic [DW-1:0] a2_dd,
  input  logic          a1_ie,
  input  logic          a2_ie,
  input  logic          intcn,
  input  logic          flag_wr,
  input  logic [1:0]    flag_wdata,
  output logic          a1_flag,
  output logic          a2_flag,
  output logic          irq_n
);

  localparam int MB = DW - 1;
  localparam int SB = DW - 2;
  localparam int DB = DW - 3;

  logic [DW-1:0] a1_tgt, a2_tgt;
  logic hit1, hit2, at_zero, clr1, clr2;

  assign a1_tgt  = a1_dd[SB] ? cur_wday : cur_mday;
  assign a2_tgt  = a2_dd[SB] ? cur_wday : cur_mday;
  assign at_zero = (cur_sec[SB:0] == '0);

  assign hit1 = (a1_sec[MB]  | (a1_sec[SB:0]  == cur_sec[SB:0]))
              & (a1_min[MB]  | (a1_min[SB:0]  == cur_min[SB:0]))
              & (a1_hour[MB] | (a1_hour[SB:0] == cur_hour[SB:0]))
              & (a1_dd[MB]   | (a1_dd[DB:0]   == a1_tgt[DB:0]));

  assign hit2 = at_zero
              & (a2_min[MB]  | (a2_min[SB:0]  == cur_min[SB:0]))
              & (a2_hour[MB] | (a2_hour[SB:0] == cur_hour[SB:0]))
              & (a2_dd[MB]   | (a2_dd[DB:0]   == a2_tgt[DB:0]));

  assign clr1 = flag_wr & ~flag_wdata[0];
  assign clr2 = flag_wr & ~flag_wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a1_flag <= 1'b0;
      a2_flag <= 1'b0;
    end else begin
      a1_flag <= (tick & hit1) | (a1_flag & ~clr1);
      a2_flag <= (tick & hit2) | (a2_flag & ~clr2);
    end
  end

  assign irq_n = ~(intcn & ((a1_flag & a1_ie) | (a2_flag & a2_ie)));

  AST_NO_SET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !a1_flag && !a2_flag) |=> (!a1_flag && !a2_flag)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (a1_flag && !clr1) |=> a1_flag); // R7
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr2 && !tick) |=> !a2_flag); // R7
  AST_A2_SEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cur_sec[SB:0] != '0 && !a2_flag) |=> !a2_flag); // R5
  AST_ALL_MASK_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && a1_sec[MB] && a1_min[MB] && a1_hour[MB] && a1_dd[MB]) |=> a1_flag); // R3
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !intcn |-> irq_n); // R10

endmodule

// File: tb/alarm_match_test.sv
module alarm_match_test;
  logic clk = 0, rst_n = 0, tick = 0;
  logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0, cur_wday = 0, cur_mday = 0;
  logic [7:0] a1_sec = 0, a1_min = 0, a1_hour = 0, a1_dd = 0, a2_min = 0, a2_hour = 0, a2_dd = 0;
  logic a1_ie = 0, a2_ie = 0, intcn = 0, flag_wr = 0;
  logic [1:0] flag_wdata = 0;
  logic a1_flag, a2_flag, irq_n;
  logic e1 = 0, e2 = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  alarm_match uut (.*);

  function automatic bit fld(input logic [7:0] a, input logic [7:0] c);
    return a[7] | (a[6:0] == c[6:0]);
  endfunction
  function automatic bit ddm(input logic [7:0] a, input logic [7:0] wd, input logic [7:0] md);
    return a[7] | (a[5:0] == (a[6] ? wd[5:0] : md[5:0]));
  endfunction
  function automatic bit m1();
    return fld(a1_sec, cur_sec) & fld(a1_min, cur_min) & fld(a1_hour, cur_hour) & ddm(a1_dd, cur_wday, cur_mday);
  endfunction
  function automatic bit m2();
    return (cur_sec[6:0] == 0) & fld(a2_min, cur_min) & fld(a2_hour, cur_hour) & ddm(a2_dd, cur_wday, cur_mday);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " a1_flag"}, a1_flag, e1);
    chk({req, " a2_flag"}, a2_flag, e2);
    chk({"R10 irq_n"}, irq_n, ~(intcn & ((e1 & a1_ie) | (e2 & a2_ie))));
  endtask

  // drive at negedge, predict, wait one edge, check at next negedge
  task automatic step(input string req);
    bit n1, n2;
    n1 = (tick & m1()) | (e1 & ~(flag_wr & ~flag_wdata[0]));
    n2 = (tick & m2()) | (e2 & ~(flag_wr & ~flag_wdata[1]));
    @(negedge clk);
    e1 = n1; e2 = n2;
    tick = 0; flag_wr = 0;
    check_all(req);
  endtask

  task automatic clear_flags();
    flag_wr = 1; flag_wdata = 2'b00; tick = 0;
    step("R7 clear");
  endtask

  function automatic logic [7:0] pick(input logic [7:0] c, input logic [7:0] other);
    return ($urandom_range(1, 0) != 0) ? {1'b0, c[6:0]} : {1'b0, other[6:0]};
  endfunction

  initial begin
    void'($urandom(1234));
    repeat (2) @(negedge clk);
    chk("R1 a1_flag reset", a1_flag, 0);
    chk("R1 a2_flag reset", a2_flag, 0);
    chk("R1 irq_n reset", irq_n, 1);
    rst_n = 1;
    a1_ie = 1; a2_ie = 1; intcn = 1;

    // R3 all masked: fires regardless of time
    a1_sec = 8'h80; a1_min = 8'h80; a1_hour = 8'h80; a1_dd = 8'h80;
    a2_min = 8'h00; a2_hour = 8'h00; a2_dd = 8'h00;
    cur_sec = 8'h37; cur_min = 8'h12; cur_hour = 8'h05; tick = 1;
    step("R3 all masked");
    chk("R3 direct a1 set", a1_flag, 1);
    chk("R5 no a2 off-zero", a2_flag, 0);
    clear_flags();

    // R6 no tick
    tick = 0; step("R6 no tick");
    chk("R6 flag stays low", a1_flag, 0);

    // R2 hour AM/PM bit mismatch
    a1_sec = 8'h80; a1_min = 8'h80; a1_hour = 8'h51; a1_dd = 8'h80;
    cur_hour = 8'h71; tick = 1;
    step("R2 am/pm mismatch");
    chk("R2 direct no set", a1_flag, 0);
    a1_hour = 8'h71; tick = 1;
    step("R2 hour match");
    chk("R9 set after tick edge", a1_flag, 1);
    // R7 write of 1 keeps flag
    flag_wr = 1; flag_wdata = 2'b11; step("R7 write one");
    chk("R7 kept", a1_flag, 1);
    // R8 set wins
    tick = 1; flag_wr = 1; flag_wdata = 2'b00; step("R8 set vs clear");
    chk("R8 set wins", a1_flag, 1);
    clear_flags();

    // R4 day vs date select
    cur_wday = 8'h03; cur_mday = 8'h21;
    a1_hour = 8'h80; a1_dd = 8'h43; tick = 1; step("R4 day select");
    chk("R4 day hit", a1_flag, 1);
    clear_flags();
    a1_dd = 8'h03; tick = 1; step("R4 date select");
    chk("R4 date miss", a1_flag, 0);

    // R5 every minute at second 00
    a2_min = 8'h80; a2_hour = 8'h80; a2_dd = 8'h80;
    cur_sec = 8'h01; tick = 1; step("R5 sec 01");
    chk("R5 no fire", a2_flag, 0);
    cur_sec = 8'h00; tick = 1; step("R5 sec 00");
    chk("R5 fire", a2_flag, 1);
    intcn = 0; #1 chk("R10 intcn gate", irq_n, 1);
    intcn = 1; a2_ie = 0; a1_ie = 0; #1 chk("R10 ie gate", irq_n, 1);
    clear_flags();

    // random phase
    for (int i = 0; i < 3000; i++) begin
      cur_sec  = ($urandom_range(2, 0) == 0) ? 8'h00 : 8'h30;
      cur_min  = ($urandom_range(1, 0) != 0) ? 8'h15 : 8'h45;
      cur_hour = ($urandom_range(1, 0) != 0) ? 8'h09 : 8'h69;
      cur_wday = 8'h05; cur_mday = 8'h17;
      a1_sec  = pick(cur_sec, 8'h59)  | {$urandom_range(1, 0) == 0, 7'd0};
      a1_min  = pick(cur_min, 8'h01)  | {$urandom_range(1, 0) == 0, 7'd0};
      a1_hour = pick(cur_hour, 8'h49) | {$urandom_range(1, 0) == 0, 7'd0};
      a1_dd   = {($urandom_range(1, 0) == 0), ($urandom_range(1, 0) != 0), ($urandom_range(1, 0) != 0) ? 6'h05 : 6'h17};
      a2_min  = pick(cur_min, 8'h02)  | {$urandom_range(1, 0) == 0, 7'd0};
      a2_hour = pick(cur_hour, 8'h29) | {$urandom_range(1, 0) == 0, 7'd0};
      a2_dd   = {($urandom_range(1, 0) == 0), ($urandom_range(1, 0) != 0), ($urandom_range(1, 0) != 0) ? 6'h05 : 6'h17};
      a1_ie = 1'($urandom_range(1, 0)); a2_ie = 1'($urandom_range(1, 0));
      intcn = ($urandom_range(3, 0) != 0);
      tick = ($urandom_range(2, 0) != 0);
      flag_wr = ($urandom_range(3, 0) == 0);
      flag_wdata = 2'($urandom_range(3, 0));
      step("R2 R4 R5 R6 R7 R8 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule